// File: doc/BRIEF.md
# Real-Mode Fetch Address Generator with Reset Override

This block turns a 16-bit code-segment selector and a 16-bit instruction offset into a 32-bit physical fetch address for a processor core running in real mode. In normal operation, the selector is moved up by four bit positions to form a segment base, and the offset is added to that base. The 20-bit sum wraps at 1 Mbyte, and the upper twelve address bits are driven to zero.

After a reset or an init, the block enters an override state. In this state it does not shift or add. It places sixteen ones above the offset, so the first fetch after reset, at offset FFF0h, goes to FFFF_FFF0h. The override stays in force until the core loads a new code-segment selector, which happens on its first far jump. From the clock edge that captures that load, the block applies the normal translation using the new selector. A status output reports whether the override is in force.

Top module: `rm_fetch_addr_gen`

## Requirements
- R1: While `rst` is high, `ovr_active` is 1 and `paddr` equals {16'hFFFF, `ofs`}. For example, offset FFF0h gives FFFF_FFF0h.
- R2: After `rst` falls, the override stays in force on every cycle until a selector load is captured. During that time `paddr` = {16'hFFFF, `ofs`} for any offset and for any selector value presented without `cs_ld`.
- R3: A `cs_ld` pulse with `rst` and `init` low clears `ovr_active` on the clock edge that samples it. The `cs_sel` value sampled on that edge is the selector used from the next cycle onward.
- R4: Outside the override, `paddr` = {12'h000, (selector·16 + `ofs`) mod 2^20}. For example, selector F000h with offset FFF0h gives 000F_FFF0h.
- R5: Outside the override, a sum that reaches 1 Mbyte wraps: the carry out of bit 19 is dropped, and bits 31:20 stay zero. For example, FFFFh:0010h gives 0000_0000h.
- R6: `init` high puts `ovr_active` to 1 and `paddr` to {16'hFFFF, `ofs`} in the same cycle, including from normal mode. After `init` falls, the override stays in force as in R2.
- R7: A `cs_ld` pulse while `rst` is high is ignored. The override stays in force on the following cycles, and the ignored selector is never used.
- R8: When `init` and `cs_ld` are high in the same cycle, `init` wins: the override is still in force on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init | input | 1 | Synchronous init request, active high |
| cs_ld | input | 1 | Code-segment selector load strobe |
| cs_sel | input | 16 | New code-segment selector |
| ofs | input | 16 | Instruction offset |
| paddr | output | 32 | Physical fetch address |
| ovr_active | output | 1 | 1 while the reset override is in force |

## Verification
The offset is stepped through the reset fetch offset, zero, and the largest value while the override holds. This shows that the upper half is forced to ones and that no shift or add takes place. After a load, fixed selector and offset pairs separate several cases: the F000h:FFF0h case that must give 000F_FFF0h, sums that wrap past 1 Mbyte and must lose their carry, and sums that land exactly on the boundary. Loads presented during reset, during init, and together with init show that the strobe is ignored or overridden in each case. A long pseudo-random stretch then mixes loads, offsets and occasional init pulses. A behavioural model in the bench predicts the status bit and the address on every cycle of that stretch.

// File: rtl/rmag_pkg.sv
package rmag_pkg;

   typedef enum logic {
      MODE_OVERRIDE = 1'b1,
      MODE_NORMAL   = 1'b0
   } rmag_mode_e;

   localparam int unsigned RMAG_SEL_W_DEF = 16;
   localparam int unsigned RMAG_OFS_W_DEF = 16;
   localparam int unsigned RMAG_SHIFT_DEF = 4;
   localparam int unsigned RMAG_PA_W_DEF  = 32;

endpackage

// File: rtl/rmag_mode_ctl.sv
module rmag_mode_ctl
   import rmag_pkg::*;
#(
   parameter int unsigned SEL_W     = RMAG_SEL_W_DEF,
   parameter logic [SEL_W-1:0] RST_SEL = 16'hF000
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             init,
   input  logic             cs_ld,
   input  logic [SEL_W-1:0] cs_sel,
   output logic             ovr_now,
   output logic [SEL_W-1:0] sel_q
);

   rmag_mode_e mode_q;
   rmag_mode_e mode_d;
   logic [SEL_W-1:0] sel_d;
   logic take_ld;

   // a load only counts when neither reset nor init is requesting override
   assign take_ld = cs_ld & ~rst & ~init;

   always_comb begin
      mode_d = mode_q;
      sel_d  = sel_q;
      if (rst) begin
         mode_d = MODE_OVERRIDE;
         sel_d  = RST_SEL;
      end else if (init) begin
         mode_d = MODE_OVERRIDE;
      end else if (take_ld) begin
         mode_d = MODE_NORMAL;
         sel_d  = cs_sel;
      end
   end

   always_ff @(posedge clk) begin
      mode_q <= mode_d;
      sel_q  <= sel_d;
   end

   // override shows in the same cycle reset or init is raised
   assign ovr_now = (mode_q == MODE_OVERRIDE) | rst | init;

   // R7: strobe under reset never leaves override
   assert_ld_in_reset_ignored_R7: assert property (@(posedge clk)
      (rst && cs_ld) |=> (mode_q == MODE_OVERRIDE));

   // R8: init beats a simultaneous load
   assert_init_beats_load_R8: assert property (@(posedge clk) disable iff (rst)
      (init && cs_ld) |=> (mode_q == MODE_OVERRIDE));

endmodule

// File: rtl/rmag_seg_adder.sv
module rmag_seg_adder
   import rmag_pkg::*;
#(
   parameter int unsigned SEL_W = RMAG_SEL_W_DEF,
   parameter int unsigned OFS_W = RMAG_OFS_W_DEF,
   parameter int unsigned SHIFT = RMAG_SHIFT_DEF
) (
   input  logic [SEL_W-1:0]       sel,
   input  logic [OFS_W-1:0]       ofs,
   output logic [SEL_W+SHIFT-1:0] lin
);

   localparam int unsigned SUM_W = SEL_W + SHIFT;

   logic [SUM_W-1:0] base;

   generate
      if (SHIFT == 0) begin : g_noshift
         assign base = sel;
      end else begin : g_shift
         assign base = {sel, {SHIFT{1'b0}}};
      end

      if (OFS_W >= SUM_W) begin : g_ofs_trunc
         // carry beyond SUM_W is dropped: wrap at 2^SUM_W
         assign lin = base + ofs[SUM_W-1:0];
      end else begin : g_ofs_ext
         assign lin = base + {{(SUM_W-OFS_W){1'b0}}, ofs};
      end
   endgenerate

endmodule

// File: rtl/rmag_addr_mux.sv
module rmag_addr_mux
   import rmag_pkg::*;
#(
   parameter int unsigned OFS_W = RMAG_OFS_W_DEF,
   parameter int unsigned SUM_W = RMAG_SEL_W_DEF + RMAG_SHIFT_DEF,
   parameter int unsigned PA_W  = RMAG_PA_W_DEF
) (
   input  logic             ovr,
   input  logic [OFS_W-1:0] ofs,
   input  logic [SUM_W-1:0] lin,
   output logic [PA_W-1:0]  paddr
);

   localparam int unsigned HI_W = PA_W - OFS_W;

   logic [PA_W-1:0] ovr_addr;
   logic [PA_W-1:0] nrm_addr;

   assign ovr_addr = {{HI_W{1'b1}}, ofs};

   generate
      if (PA_W > SUM_W) begin : g_zero_fill
         assign nrm_addr = {{(PA_W-SUM_W){1'b0}}, lin};
      end else begin : g_exact
         assign nrm_addr = lin;
      end
   endgenerate

   assign paddr = ovr ? ovr_addr : nrm_addr;

endmodule

// File: rtl/rm_fetch_addr_gen.sv
module rm_fetch_addr_gen
   import rmag_pkg::*;
#(
   parameter int unsigned SEL_W = RMAG_SEL_W_DEF,
   parameter int unsigned OFS_W = RMAG_OFS_W_DEF,
   parameter int unsigned SHIFT = RMAG_SHIFT_DEF,
   parameter int unsigned PA_W  = RMAG_PA_W_DEF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             init,
   input  logic             cs_ld,
   input  logic [SEL_W-1:0] cs_sel,
   input  logic [OFS_W-1:0] ofs,
   output logic [PA_W-1:0]  paddr,
   output logic             ovr_active
);

   localparam int unsigned SUM_W = SEL_W + SHIFT;
   localparam int unsigned HI_W  = PA_W - OFS_W;

   generate
      if (PA_W < SUM_W) begin : g_bad_pa
         $error("rm_fetch_addr_gen: PA_W must hold the shifted sum");
      end
      if (OFS_W >= PA_W) begin : g_bad_ofs
         $error("rm_fetch_addr_gen: OFS_W must leave room for forced bits");
      end
      if (OFS_W > SUM_W) begin : g_bad_sum
         $error("rm_fetch_addr_gen: offset wider than segment sum");
      end
   endgenerate

   logic [SEL_W-1:0] sel_q;
   logic [SUM_W-1:0] lin;
   logic             ovr;

   rmag_mode_ctl #(.SEL_W(SEL_W), .RST_SEL(SEL_W'(16'hF000))) u_mode (
      .clk     (clk),
      .rst     (rst),
      .init    (init),
      .cs_ld   (cs_ld),
      .cs_sel  (cs_sel),
      .ovr_now (ovr),
      .sel_q   (sel_q)
   );

   rmag_seg_adder #(.SEL_W(SEL_W), .OFS_W(OFS_W), .SHIFT(SHIFT)) u_add (
      .sel (sel_q),
      .ofs (ofs),
      .lin (lin)
   );

   rmag_addr_mux #(.OFS_W(OFS_W), .SUM_W(SUM_W), .PA_W(PA_W)) u_mux (
      .ovr   (ovr),
      .ofs   (ofs),
      .lin   (lin),
      .paddr (paddr)
   );

   assign ovr_active = ovr;

   // R1: reset shows override immediately (immediate check, sampled after settle)
   always_comb begin
      if (rst === 1'b1) begin
         assert_reset_override_R1: assert (ovr_active === 1'b1);
      end
   end

   // R2: override persists without a load
   assert_override_holds_R2: assert property (@(posedge clk) disable iff (rst)
      (ovr_active && !cs_ld) |=> ovr_active);

   // R2: forced upper bits while override is on
   assert_override_upper_R2: assert property (@(posedge clk) disable iff (rst)
      ovr_active |-> (paddr[PA_W-1:OFS_W] == {HI_W{1'b1}} && paddr[OFS_W-1:0] == ofs));

   // R3: a clean load ends override on the next cycle unless init arrives
   assert_load_clears_R3: assert property (@(posedge clk) disable iff (rst)
      (cs_ld && !init) |=> (init || !ovr_active));

   // R5: normal-mode address never exceeds the 20-bit space
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
      !ovr_active |-> (paddr[PA_W-1:SUM_W] == '0));

   // R6: init forces override in the same cycle
   assert_init_override_R6: assert property (@(posedge clk) disable iff (rst)
      init |-> ovr_active);

endmodule

// File: tb/tb_rm_fetch_addr_gen.sv
module tb_rm_fetch_addr_gen;

   logic        clk = 1'b0;
   logic        rst, init, cs_ld;
   logic [15:0] cs_sel, ofs;
   logic [31:0] paddr;
   logic        ovr_active;

   int checks = 0;
   int errors = 0;

   // behavioural reference state
   bit          m_ovr;
   int unsigned m_cs;
   logic [31:0] rng = 32'h1234_5678;

   always #10 clk = ~clk;

   rm_fetch_addr_gen dut (
      .clk(clk), .rst(rst), .init(init), .cs_ld(cs_ld),
      .cs_sel(cs_sel), .ofs(ofs), .paddr(paddr), .ovr_active(ovr_active)
   );

   function automatic logic [31:0] exp_addr(bit ov, int unsigned cs, logic [15:0] o);
      int unsigned s;
      if (ov) return {16'hFFFF, o};
      s = ((cs << 4) + int'(o)) & 32'h000F_FFFF;
      return s;
   endfunction

   task automatic check_now(string tag);
      bit ov_e;
      logic [31:0] a_e;
      ov_e = m_ovr | rst | init;
      a_e  = exp_addr(ov_e, m_cs, ofs);
      checks++;
      if (ovr_active !== ov_e) begin
         errors++;
         $display("FAIL %s ovr_active actual %0b expected %0b", tag, ovr_active, ov_e);
      end
      checks++;
      if (paddr !== a_e) begin
         errors++;
         $display("FAIL %s paddr actual %h expected %h", tag, paddr, a_e);
      end
   endtask

   // drive at negedge, check mid-low phase, then model the rising edge
   task automatic step(bit r, bit in, bit ld, logic [15:0] sel, logic [15:0] o, string tag);
      @(negedge clk);
      rst = r; init = in; cs_ld = ld; cs_sel = sel; ofs = o;
      #2;
      check_now(tag);
      @(posedge clk);
      if (r) begin
         m_ovr = 1'b1; m_cs = 32'hF000;
      end else if (in) begin
         m_ovr = 1'b1;
      end else if (ld) begin
         m_ovr = 1'b0; m_cs = sel;
      end
   endtask

   function automatic logic [31:0] nxt(logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; init = 1'b0; cs_ld = 1'b0; cs_sel = '0; ofs = 16'hFFF0;
      m_ovr = 1'b1; m_cs = 32'hF000;
      // R1: reset state, reset fetch address FFFF_FFF0
      step(1, 0, 0, 16'h0000, 16'hFFF0, "R1");
      step(1, 0, 0, 16'h0000, 16'h1234, "R1");
      // R7: load during reset ignored
      step(1, 0, 1, 16'h1234, 16'hFFF0, "R7");
      step(0, 0, 0, 16'h5555, 16'hFFF0, "R7");
      // R2: override holds across offsets
      step(0, 0, 0, 16'hABCD, 16'h0000, "R2");
      step(0, 0, 0, 16'h0000, 16'hFFFF, "R2");
      // R3: far jump load F000, then R4 F000:FFF0 -> 000F_FFF0
      step(0, 0, 1, 16'hF000, 16'hFFF0, "R3");
      step(0, 0, 0, 16'h0000, 16'hFFF0, "R4");
      step(0, 0, 0, 16'h0000, 16'h0000, "R4");
      // R5: wrap past 1 Mbyte
      step(0, 0, 1, 16'hFFFF, 16'h0010, "R3");
      step(0, 0, 0, 16'h0000, 16'h0010, "R5");
      step(0, 0, 0, 16'h0000, 16'h000F, "R5");
      step(0, 0, 0, 16'h0000, 16'hFFFF, "R5");
      // R6: init from normal mode
      step(0, 1, 0, 16'h0000, 16'hFFF0, "R6");
      step(0, 0, 0, 16'h0000, 16'h0042, "R6");
      // R8: init together with load
      step(0, 1, 1, 16'h2000, 16'h0100, "R8");
      step(0, 0, 0, 16'h0000, 16'h0100, "R8");
      step(0, 0, 1, 16'h2000, 16'h0100, "R3");
      step(0, 0, 0, 16'h0000, 16'h0100, "R4");
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [15:0] s, o;
         bit ld, in;
         rng = nxt(rng); s = rng[15:0]; o = rng[31:16];
         rng = nxt(rng); ld = (rng[2:0] == 3'd0); in = (rng[9:4] == 6'd0);
         step(0, in, ld, s, o, "R4");
      end
      // reset again from normal mode
      step(1, 0, 0, 16'h0000, 16'hFFF0, "R1");
      step(0, 0, 0, 16'h0000, 16'hFFF0, "R2");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule